// File: doc/BRIEF.md
# Successive-Approximation Converter Serial Port (Device Side)

This block is the digital slave logic behind the four-wire serial interface of a 16-bit successive-approximation converter. A host pulls chip select low and clocks bits in on DIN. Any number of low bits may come before the first high bit. That high bit begins an 8-bit control byte, and one bit of the byte chooses how the conversion is clocked. In external-clock mode the host's serial clock paces the conversion: a status strobe marks the end of the conversion, and the result follows MSB first. In internal-clock mode the block times the conversion itself. The strobe stays low while the conversion runs and rises when the result is stored. The host can then read the word at any later time.

Every pin is oversampled by a fast internal clock (`clk`) through a configurable synchronizer chain. Each SCLK level must therefore last several `clk` periods. The analog converter is replaced by a stub. In internal mode the stub counts `CONV_CYCLES` clocks and then presents the value on `analog_code`. In external mode that value is taken on the 15th falling SCLK edge. The pads are modelled as values gated by output-enable signals, which float to high impedance when the enable is low.

Control byte, first bit on the wire first: start(1), unipolar/bipolar, clock-mode select (1 = internal, 0 = external), two mode bits, three channel bits. The clock-mode select is byte bit 5 when the start bit is counted as bit 7. Only the start bit and the clock-mode select act on this block.

Top module: `sar_serial_port`

## Requirements
- R1: While chip select is low, DIN is sampled on each rising SCLK edge. Low bits before the first high bit are ignored. The first high bit is the start bit, and the following seven rising edges complete the control byte. The third bit on the wire (byte bit 5) set to 1 selects internal-clock mode.
- R2: In external-clock mode the strobe is low up to the 14th falling SCLK edge counted from the start bit. It is high from the 15th falling edge until the 16th, and low again afterwards.
- R3: In external-clock mode, DOUT shows result bit 15 from the 16th falling edge on. Each of the next 15 falling edges moves to the next lower bit, down to bit 0.
- R4: After bit 0 has been shown, DOUT reads 0 on every further falling edge until a new start bit arrives.
- R5: In external-clock mode, while chip select is high, both strobe and DOUT are released (enables low, pads at high impedance).
- R6: In external-clock mode, SCLK and DIN are ignored while chip select is high. The position in the transfer is kept, so the transfer carries on unchanged once chip select returns low.
- R7: In internal-clock mode the conversion starts at the 8th falling edge. The strobe stays low for `CONV_CYCLES` clock periods, and that count is limited at elaboration to `CONV_MAX`.
- R8: In internal-clock mode, result bit 15 is on DOUT when the strobe rises. The next 15 falling SCLK edges move through bits 14 down to 0.
- R9: In internal-clock mode the strobe stays driven while chip select is high, and the conversion still completes if chip select is released after the control byte.
- R10: A start bit seen during readout abandons the remaining result bits and begins a new control-byte capture.
- R11: After reset the strobe is low, the block is in external-clock mode, and DOUT reads 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Internal oversampling and conversion clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cs_n | input | 1 | Chip select, active low |
| sclk | input | 1 | Serial clock from the host |
| din | input | 1 | Serial data in (control byte) |
| analog_code | input | RES_BITS | Word supplied by the converter stub |
| dout_pad | output | 1 | Serial data out, high impedance when disabled |
| dout_oe | output | 1 | Output enable of the DOUT pad |
| strb_pad | output | 1 | Conversion status strobe, high impedance when disabled |
| strb_oe | output | 1 | Output enable of the strobe pad |

## Verification
Transfers are run in both clock modes with random result words. The words include patterns with only the MSB and LSB set, so a shift-order or off-by-one error in bit placement cannot pass. Runs with leading zero bits before the start bit separate proper start-bit hunting from a fixed byte alignment. Runs that raise chip select in the middle of the control byte, the conversion or the readout, and toggle SCLK with DIN high during those gaps, separate a held transfer from one that moves or restarts. A readout cut short by a new start bit must produce the next word, not trailing zeros.

// File: rtl/sar_port_pkg.sv
`timescale 1ns/1ps
package sar_port_pkg;
   // Transfer phases of the serial port
   typedef enum logic [2:0] {
      ST_IDLE,
      ST_CTRL,
      ST_EXTCONV,
      ST_INTCONV,
      ST_READOUT
   } port_state_t;
endpackage

// File: rtl/sar_in_sync.sv
`timescale 1ns/1ps
// Oversampling synchronizer for the three serial input pins plus
// SCLK edge detection, gated by the synchronized chip select.
module sar_in_sync #(
   parameter int STAGES = 2
) (
   input  logic clk,
   input  logic rst_n,
   input  logic cs_n,
   input  logic sclk,
   input  logic din,
   output logic cs_act,
   output logic sclk_rise,
   output logic sclk_fall,
   output logic din_s
);
   localparam int LAST = STAGES - 1;
   // pin order inside a stage: {cs_n, sclk, din}; idle levels on reset
   localparam logic [2:0] IDLE_LVL = 3'b100;

   generate
      if (STAGES < 2) begin : g_bad_stages
         $error("sar_in_sync: STAGES must be at least 2");
      end
   endgenerate

   logic [STAGES-1:0][2:0] pipe;
   logic                   sclk_q;

   generate
      for (genvar g = 0; g < STAGES; g++) begin : g_stage
         if (g == 0) begin : g_first
            always_ff @(posedge clk or negedge rst_n) begin
               if (!rst_n) pipe[g] <= IDLE_LVL;
               else        pipe[g] <= {cs_n, sclk, din};
            end
         end else begin : g_next
            always_ff @(posedge clk or negedge rst_n) begin
               if (!rst_n) pipe[g] <= IDLE_LVL;
               else        pipe[g] <= pipe[g-1];
            end
         end
      end
   endgenerate

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) sclk_q <= 1'b0;
      else        sclk_q <= pipe[LAST][1];
   end

   assign cs_act    = ~pipe[LAST][2];
   assign din_s     = pipe[LAST][0];
   assign sclk_rise = cs_act &  pipe[LAST][1] & ~sclk_q;
   assign sclk_fall = cs_act & ~pipe[LAST][1] &  sclk_q;
endmodule

// File: rtl/sar_conv_stub.sv
`timescale 1ns/1ps
// Stand-in for the analog conversion: a fixed-length busy interval.
module sar_conv_stub #(
   parameter int CONV_CYCLES = 40,
   parameter int CONV_MAX    = 1400
) (
   input  logic clk,
   input  logic rst_n,
   input  logic start,
   output logic done
);
   localparam int CW = $clog2(CONV_CYCLES + 1);
   localparam logic [CW-1:0] LAST = CW'(CONV_CYCLES - 1);

   generate
      if (CONV_CYCLES < 1 || CONV_CYCLES > CONV_MAX) begin : g_bad_conv
         $error("sar_conv_stub: CONV_CYCLES outside 1..CONV_MAX");
      end
   endgenerate

   logic          busy;
   logic [CW-1:0] cnt;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         busy <= 1'b0;
         cnt  <= '0;
         done <= 1'b0;
      end else begin
         done <= 1'b0;
         if (start) begin
            busy <= 1'b1;
            cnt  <= '0;
         end else if (busy) begin
            if (cnt == LAST) begin
               busy <= 1'b0;
               done <= 1'b1;
            end else begin
               cnt <= cnt + 1'b1;
            end
         end
      end
   end

   // R7: a new conversion is never requested while one is running
   a_r7_no_restart: assert property (@(posedge clk) disable iff (!rst_n)
      start |-> !busy);
   // R7: completion is reported only once the busy interval has ended
   a_r7_done_idle: assert property (@(posedge clk) disable iff (!rst_n)
      done |-> !busy);
endmodule

// File: rtl/sar_out_shift.sv
`timescale 1ns/1ps
// Result holding register, shifted out MSB first with zero fill.
module sar_out_shift #(
   parameter int WIDTH = 16
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             clear,
   input  logic             load,
   input  logic             shift,
   input  logic [WIDTH-1:0] data,
   output logic             msb
);
   localparam int SW = $clog2(WIDTH + 1);
   localparam logic [SW-1:0] ALL_OUT = SW'(WIDTH);

   generate
      if (WIDTH < 2) begin : g_bad_width
         $error("sar_out_shift: WIDTH must be at least 2");
      end
   endgenerate

   logic [WIDTH-1:0] hold;
   logic [SW-1:0]    shifts;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         hold <= '0;
      end else if (clear) begin
         hold <= '0;
      end else if (load) begin
         hold <= data;
      end else if (shift) begin
         hold <= {hold[WIDTH-2:0], 1'b0};
      end
   end

   // shifts since the last load, saturating; used to check zero fill
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)                          shifts <= ALL_OUT;
      else if (clear || load)              shifts <= '0;
      else if (shift && shifts != ALL_OUT) shifts <= shifts + 1'b1;
   end

   assign msb = hold[WIDTH-1];

   // R3: after a load the output bit is the top bit of the stored word
   a_r3_msb_first: assert property (@(posedge clk) disable iff (!rst_n)
      load |=> (msb == $past(data[WIDTH-1])));
   // R4: once every bit has left, only zeros remain
   a_r4_zero_fill: assert property (@(posedge clk) disable iff (!rst_n)
      (shifts == ALL_OUT) |-> (hold == '0));
endmodule

// File: rtl/sar_port_fsm.sv
`timescale 1ns/1ps
// Transfer sequencer: start-bit hunt, control byte, mode-dependent
// conversion phase and readout.
module sar_port_fsm
   import sar_port_pkg::*;
#(
   parameter int RES_BITS  = 16,
   parameter int CTRL_BITS = 8,
   parameter int MODE_BIT  = 5
) (
   input  logic clk,
   input  logic rst_n,
   input  logic cs_act,
   input  logic sclk_rise,
   input  logic sclk_fall,
   input  logic din_s,
   input  logic conv_done,
   output logic int_mode,
   output logic strb,
   output logic readout,
   output logic conv_start,
   output logic load,
   output logic shift,
   output logic clear
);
   localparam int RC_W = $clog2(CTRL_BITS);
   localparam int FC_W = $clog2(RES_BITS + 1);
   localparam logic [RC_W-1:0] MODE_RISE   = RC_W'(CTRL_BITS - 1 - MODE_BIT);
   localparam logic [FC_W-1:0] FC_CTRL_END = FC_W'(CTRL_BITS);
   localparam logic [FC_W-1:0] FC_STRB_ON  = FC_W'(RES_BITS - 1);
   localparam logic [FC_W-1:0] FC_MSB      = FC_W'(RES_BITS);

   generate
      if (MODE_BIT < 0 || MODE_BIT >= CTRL_BITS - 1) begin : g_bad_mode
         $error("sar_port_fsm: MODE_BIT must lie below the start bit");
      end
      if (RES_BITS <= CTRL_BITS + 1) begin : g_bad_res
         $error("sar_port_fsm: RES_BITS must exceed CTRL_BITS + 1");
      end
   endgenerate

   port_state_t     state;
   logic [RC_W-1:0] rise_cnt;
   logic [FC_W-1:0] fall_cnt;
   logic [FC_W-1:0] fall_nxt;
   logic            int_sel;
   logic            start_evt;

   assign fall_nxt   = fall_cnt + 1'b1;
   assign start_evt  = sclk_rise & din_s & (state == ST_IDLE || state == ST_READOUT);
   assign clear      = start_evt;
   assign shift      = sclk_fall & (state == ST_READOUT);
   assign conv_start = sclk_fall & (state == ST_CTRL) & (fall_nxt == FC_CTRL_END) & int_sel;
   assign load       = (sclk_fall & (state == ST_EXTCONV) & (fall_nxt == FC_STRB_ON))
                     | ((state == ST_INTCONV) & conv_done);
   assign readout    = (state == ST_READOUT);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         state    <= ST_IDLE;
         rise_cnt <= '0;
         fall_cnt <= '0;
         int_sel  <= 1'b0;
         int_mode <= 1'b0;
         strb     <= 1'b0;
      end else begin
         case (state)
            ST_IDLE, ST_READOUT: begin
               if (start_evt) begin
                  state    <= ST_CTRL;
                  rise_cnt <= RC_W'(1);
                  fall_cnt <= '0;
                  strb     <= 1'b0;
               end
            end
            ST_CTRL: begin
               if (sclk_rise) begin
                  rise_cnt <= rise_cnt + 1'b1;
                  if (rise_cnt == MODE_RISE) int_sel <= din_s;
               end
               if (sclk_fall) begin
                  fall_cnt <= fall_nxt;
                  if (fall_nxt == FC_CTRL_END) begin
                     int_mode <= int_sel;
                     state    <= int_sel ? ST_INTCONV : ST_EXTCONV;
                  end
               end
            end
            ST_EXTCONV: begin
               if (sclk_fall) begin
                  fall_cnt <= fall_nxt;
                  if (fall_nxt == FC_STRB_ON) strb <= 1'b1;
                  if (fall_nxt == FC_MSB) begin
                     strb  <= 1'b0;
                     state <= ST_READOUT;
                  end
               end
            end
            ST_INTCONV: begin
               if (conv_done) begin
                  strb  <= 1'b1;
                  state <= ST_READOUT;
               end
            end
            default: state <= ST_IDLE;
         endcase
      end
   end

   // R2: the external-mode strobe ends at the next falling edge
   a_r2_ext_strb_single: assert property (@(posedge clk) disable iff (!rst_n)
      (strb && !int_mode && sclk_fall) |=> !strb);
   // R6: with chip select high, an external transfer does not move
   a_r6_ext_frozen: assert property (@(posedge clk) disable iff (!rst_n)
      (!cs_act && !int_mode && state != ST_INTCONV)
      |=> ($stable(state) && $stable(fall_cnt) && $stable(rise_cnt)));
   // R7: strobe is low for the whole internal conversion
   a_r7_strb_low_conv: assert property (@(posedge clk) disable iff (!rst_n)
      (state == ST_INTCONV) |-> !strb);
   // R8: conversion completion raises the strobe together with readout
   a_r8_done_to_readout: assert property (@(posedge clk) disable iff (!rst_n)
      conv_done |=> (state == ST_READOUT && strb));
   // R10: a start bit during readout restarts control capture
   a_r10_abort: assert property (@(posedge clk) disable iff (!rst_n)
      (sclk_rise && din_s && state == ST_READOUT) |=> (state == ST_CTRL));
endmodule

// File: rtl/sar_serial_port.sv
`timescale 1ns/1ps
// Device-side serial port of a successive-approximation converter.
module sar_serial_port #(
   parameter int RES_BITS    = 16,
   parameter int CTRL_BITS   = 8,
   parameter int MODE_BIT    = 5,
   parameter int SYNC_STAGES = 2,
   parameter int CONV_CYCLES = 40,
   parameter int CONV_MAX    = 1400
) (
   input  logic                clk,
   input  logic                rst_n,
   input  logic                cs_n,
   input  logic                sclk,
   input  logic                din,
   input  logic [RES_BITS-1:0] analog_code,
   output logic                dout_pad,
   output logic                dout_oe,
   output logic                strb_pad,
   output logic                strb_oe
);
   logic cs_act, sclk_rise, sclk_fall, din_s;
   logic conv_start, conv_done;
   logic int_mode, strb, readout, load, shift, clear;
   logic msb;

   sar_in_sync #(.STAGES(SYNC_STAGES)) u_sync (
      .clk       (clk),
      .rst_n     (rst_n),
      .cs_n      (cs_n),
      .sclk      (sclk),
      .din       (din),
      .cs_act    (cs_act),
      .sclk_rise (sclk_rise),
      .sclk_fall (sclk_fall),
      .din_s     (din_s)
   );

   sar_port_fsm #(
      .RES_BITS  (RES_BITS),
      .CTRL_BITS (CTRL_BITS),
      .MODE_BIT  (MODE_BIT)
   ) u_fsm (
      .clk        (clk),
      .rst_n      (rst_n),
      .cs_act     (cs_act),
      .sclk_rise  (sclk_rise),
      .sclk_fall  (sclk_fall),
      .din_s      (din_s),
      .conv_done  (conv_done),
      .int_mode   (int_mode),
      .strb       (strb),
      .readout    (readout),
      .conv_start (conv_start),
      .load       (load),
      .shift      (shift),
      .clear      (clear)
   );

   sar_conv_stub #(
      .CONV_CYCLES (CONV_CYCLES),
      .CONV_MAX    (CONV_MAX)
   ) u_conv (
      .clk   (clk),
      .rst_n (rst_n),
      .start (conv_start),
      .done  (conv_done)
   );

   sar_out_shift #(.WIDTH(RES_BITS)) u_shift (
      .clk   (clk),
      .rst_n (rst_n),
      .clear (clear),
      .load  (load),
      .shift (shift),
      .data  (analog_code),
      .msb   (msb)
   );

   // pad models: the data pad follows chip select; the strobe pad stays
   // driven in internal-clock mode
   assign dout_oe  = ~cs_n;
   assign strb_oe  = int_mode | ~cs_n;
   assign dout_pad = dout_oe ? (readout & msb) : 1'bz;
   assign strb_pad = strb_oe ? strb : 1'bz;
endmodule

// File: tb/sar_serial_port_bench.sv
`timescale 1ns/1ps
module sar_serial_port_bench;
   localparam int RES  = 16;
   localparam int CONV = 40;
   localparam int HALF = 8;   // clk periods per SCLK level

   logic           clk = 1'b0;
   logic           rst_n = 1'b0;
   logic           cs_n = 1'b1;
   logic           sclk = 1'b0;
   logic           din = 1'b0;
   logic [RES-1:0] analog_code = '0;
   wire            dout_pad;
   wire            dout_oe;
   wire            strb_pad;
   wire            strb_oe;

   int    n_cmp = 0;
   int    n_bad = 0;
   bit    ended = 1'b0;
   string ctx = "reset";

   always #2.5 clk = ~clk;

   sar_serial_port #(.RES_BITS(RES), .CONV_CYCLES(CONV)) u_sar_serial_port (
      .clk         (clk),
      .rst_n       (rst_n),
      .cs_n        (cs_n),
      .sclk        (sclk),
      .din         (din),
      .analog_code (analog_code),
      .dout_pad    (dout_pad),
      .dout_oe     (dout_oe),
      .strb_pad    (strb_pad),
      .strb_oe     (strb_oe)
   );

   // expected DOUT after n bits of the word have been shown (n = 0 is MSB)
   function automatic logic exp_out(input logic [RES-1:0] code, input int n);
      if (n < RES) return code[RES-1-n];
      return 1'b0;
   endfunction

   // expected external-mode strobe after the k-th falling edge
   function automatic logic exp_ext_strb(input int k);
      return (k == RES - 1);
   endfunction

   task automatic summary();
      if (!ended) begin
         ended = 1'b1;
         $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
         $finish;
      end
   endtask

   task automatic chk(input string req, input logic act, input logic exp);
      n_cmp++;
      if (act !== exp) begin
         n_bad++;
         $display("FAIL %s [%s]: actual %b expected %b", req, ctx, act, exp);
      end
   endtask

   task automatic wclk(input int n);
      repeat (n) @(negedge clk);
   endtask

   task automatic pulse(input logic d);
      din  = d;
      sclk = 1'b1;
      wclk(HALF);
      sclk = 1'b0;
      wclk(HALF);
   endtask

   // release chip select, toggle SCLK with DIN high, then reselect
   task automatic cs_gap(input bit chk_oe, input logic exp_oe, input string req);
      cs_n = 1'b1;
      wclk(4);
      if (chk_oe) begin
         chk(req, strb_oe, exp_oe);
         chk(req, dout_oe, 1'b0);
      end
      pulse(1'b1);
      pulse(1'b1);
      din  = 1'b0;
      cs_n = 1'b0;
      wclk(4);
   endtask

   task automatic xfer(input bit intm, input logic [RES-1:0] code,
                       input int lead, input bit split, input int nread);
      logic [7:0] ctrl;
      analog_code = code;
      for (int i = 0; i < lead; i++) pulse(1'b0);
      // start, unipolar/bipolar, clock-mode select, mode bits, channel bits
      ctrl = {1'b1, 1'b0, intm, 5'b11010};
      for (int i = 7; i >= 0; i--) begin
         pulse(ctrl[i]);
         if (split && i == 4) cs_gap(1'b0, 1'b0, "R6");
      end
      if (!intm) begin
         for (int k = 9; k <= RES; k++) begin
            pulse(1'b0);
            if (split && k == 11) cs_gap(1'b1, 1'b0, "R5");
            if (k >= RES - 2) chk("R2", strb_pad, exp_ext_strb(k));
         end
         chk("R3", dout_pad, exp_out(code, 0));
      end else begin
         chk("R7", strb_pad, 1'b0);
         if (split) begin
            cs_n = 1'b1;
            wclk(4);
            chk("R9", strb_oe, 1'b1);
         end
         wclk(CONV - 20);
         chk("R7", strb_pad, 1'b0);
         wclk(30);
         chk("R8", strb_pad, 1'b1);
         if (split) begin
            chk("R9", strb_oe, 1'b1);
            cs_n = 1'b0;
            wclk(4);
         end
         chk("R8", dout_pad, exp_out(code, 0));
      end
      for (int j = 1; j <= nread; j++) begin
         pulse(1'b0);
         if (split && j == 8) cs_gap(1'b1, intm, intm ? "R9" : "R5");
         if (j < RES) chk(intm ? "R8" : "R3", dout_pad, exp_out(code, j));
         else         chk("R4", dout_pad, 1'b0);
      end
   endtask

   initial begin
      repeat (150000) @(posedge clk);
      n_cmp++;
      n_bad++;
      $display("FAIL watchdog [%s]: actual timeout expected completion", ctx);
      summary();
   end

   initial begin
      void'($urandom(32'd7));
      wclk(10);
      // R11: reset state with chip select high
      chk("R11", strb_oe, 1'b0);
      chk("R11", dout_oe, 1'b0);
      rst_n = 1'b1;
      wclk(4);
      cs_n = 1'b0;
      wclk(6);
      chk("R11", strb_oe, 1'b1);
      chk("R11", strb_pad, 1'b0);
      chk("R11", dout_pad, 1'b0);

      ctx = "external basic";
      xfer(1'b0, 16'hA5C3, 0, 1'b0, RES + 1);
      ctx = "R1 leading zeros, internal";
      xfer(1'b1, 16'h8001, 2, 1'b0, RES + 1);
      ctx = "R6 split external";
      xfer(1'b0, 16'h7FFE, 1, 1'b1, RES + 1);
      ctx = "R9 split internal";
      xfer(1'b1, 16'h3C5A, 0, 1'b1, RES + 1);
      ctx = "R10 abort setup";
      xfer(1'b0, 16'h1234, 0, 1'b0, 3);
      ctx = "R10 abort follow-on";
      xfer(1'b1, 16'hF00F, 0, 1'b0, RES + 1);
      ctx = "R10 abort back to external";
      xfer(1'b0, 16'h0F0F, 0, 1'b0, 5);
      xfer(1'b0, 16'hC001, 0, 1'b0, RES + 1);

      for (int r = 0; r < 8; r++) begin
         logic           m;
         logic [RES-1:0] c;
         int             ld;
         logic           sp;
         m  = 1'($urandom % 2);
         c  = RES'($urandom);
         ld = int'($urandom % 3);
         sp = 1'($urandom % 2);
         ctx = $sformatf("random %0d", r);
         xfer(m, c, ld, sp, RES + 2);
      end
      summary();
   end
endmodule